// File: doc/BRIEF.md
# NAND Flash Single-Register Bridge

This bridge lets a processor run a raw 8-bit NAND flash device through one 32-bit register on a simple request/acknowledge bus. A register write carries a 3-bit operation code, a chip-enable request and one byte. The bridge turns it into a command latch, an address latch or a data write strobe on the flash pins, or it arms read mode. In read mode every register read fires one read strobe and returns the next byte that the flash presents. A read outside read mode only reports status and the last byte captured. Bit 15 of every read carries the device's busy state, taken through a two-flop synchroniser.

One state machine sequences the pins. From `ST_IDLE` a register write with a strobe op goes to `ST_WR_SETUP` (strobes and data driven, write strobe high). It then goes to `ST_WR_PULSE` (write strobe low) and to `ST_WR_HOLD` (write strobe high, strobes and data still held), and ends in `ST_DONE`. A register read in read mode goes from `ST_IDLE` to `ST_RD_PULSE` (read strobe low) and `ST_RD_RECOV` (read strobe high), then to `ST_DONE`. Every other access goes from `ST_IDLE` straight to `ST_DONE`. `ST_DONE` raises the acknowledge for one cycle and always returns to `ST_IDLE`. A small down-counter sets how long each timed state lasts.

Top module: `nand_reg_bridge`

## Requirements
- R1: On a register write, bits 30:28 select the cycle: 0 is a command latch (CLE high), 1 is an address latch (ALE high) and 3 is a data write (CLE and ALE low). Each gives exactly one write-strobe pulse, with bits 23:16 on `nand_dq_o`. CLE and ALE are never high together.
- R2: A write cycle keeps the write strobe high for WE_HI_CYC cycles with data driven, then low for WE_LO_CYC cycles, then high for WE_HI_CYC cycles before release. `nand_dq_o`, CLE and ALE stay stable while the strobe is low.
- R3: Bit 31 of every register write sets the chip enable. When it is 1, `nand_ce_n` is driven low from the accepting edge on. When it is 0, `nand_ce_n` goes high. Register reads leave the chip enable as it is.
- R4: A write with op code 2 produces no strobe and enters read mode. In read mode each register read gives exactly one read-strobe pulse: RE_LO_CYC cycles low, then RE_HI_CYC cycles high before the acknowledge. Write and read strobes are never low together.
- R5: The byte on `nand_dq_i` is captured as the read strobe rises and is returned in bits 23:16. Successive reads in read mode return successive flash bytes.
- R6: A write with op code 4 to 7 updates only the chip enable. It makes no strobe and leaves read mode unchanged. Op codes 0, 1 and 3 leave read mode.
- R7: A register read outside read mode makes no read strobe and returns the last captured byte.
- R8: Bit 15 of a register read is 1 when `nand_rb_n` has been low (busy) for at least two clocks before the acknowledge, and 0 when it has been high that long.
- R9: Bits 31:24 and 14:0 of a register read are zero.
- R10: `nand_dq_oe` is high only during write cycles (for 2*WE_HI_CYC+WE_LO_CYC cycles each) and never while the read strobe is low.
- R11: `bus_ack` is a one-cycle pulse, given only after both strobes have returned high.
- R12: After reset: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, CLE, ALE, `nand_dq_oe` and `bus_ack` are low, read mode is off and the last captured byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access completion |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Ready/busy line, low = busy |

## Verification
The busy report and a read-mode fetch can meet in the same access: the busy line may change while the read strobe is low. The bench provokes this by dropping `nand_rb_n` once it sees the read strobe fall. It then expects the acknowledged word to carry both the correctly fetched byte and a busy bit of 1, because the strobe and recovery phases give the synchroniser time to settle. Random traffic also changes the busy line between accesses, and every read is checked for byte, busy bit and zero padding together.

// File: rtl/nandbr_pkg.sv
package nandbr_pkg;
    localparam int CE_BIT   = 31;
    localparam int OP_MSB   = 30;
    localparam int OP_LSB   = 28;
    localparam int BYTE_MSB = 23;
    localparam int BYTE_LSB = 16;
    localparam int BUSY_BIT = 15;

    localparam logic [2:0] OPC_CMD    = 3'd0;
    localparam logic [2:0] OPC_ADDR   = 3'd1;
    localparam logic [2:0] OPC_RDMODE = 3'd2;
    localparam logic [2:0] OPC_WRDATA = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_PULSE,
        ST_RD_RECOV,
        ST_DONE
    } brg_state_t;

    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } wr_kind_t;
endpackage

// File: rtl/nandbr_sync.sv
module nandbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nandbr_timer.sv
module nandbr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nandbr_fsm.sv
module nandbr_fsm
    import nandbr_pkg::*;
#(
    parameter int WE_LO_CYC = 2,
    parameter int WE_HI_CYC = 2,
    parameter int RE_LO_CYC = 2,
    parameter int RE_HI_CYC = 2,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_ack,
    input  logic             busy_sync,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_expired,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i
);
    brg_state_t state_q, state_d;
    wr_kind_t   kind_q;
    logic       ce_q;
    logic       rdmode_q;
    logic [7:0] wbyte_q;
    logic [7:0] rbyte_q;
    logic [2:0] req_op;
    logic       wr_phase;

    assign req_op = bus_wdata[OP_MSB:OP_LSB];

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    if (bus_we) begin
                        if (req_op == OPC_CMD || req_op == OPC_ADDR || req_op == OPC_WRDATA)
                            state_d = ST_WR_SETUP;
                        else
                            state_d = ST_DONE;
                    end else if (rdmode_q) begin
                        state_d = ST_RD_PULSE;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_WR_SETUP: if (tmr_expired) state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_expired) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  if (tmr_expired) state_d = ST_DONE;
            ST_RD_PULSE: if (tmr_expired) state_d = ST_RD_RECOV;
            ST_RD_RECOV: if (tmr_expired) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_SETUP, ST_WR_HOLD: tmr_val = CNT_W'(WE_HI_CYC - 1);
            ST_WR_PULSE:             tmr_val = CNT_W'(WE_LO_CYC - 1);
            ST_RD_PULSE:             tmr_val = CNT_W'(RE_LO_CYC - 1);
            ST_RD_RECOV:             tmr_val = CNT_W'(RE_HI_CYC - 1);
            default:                 tmr_val = '0;
        endcase
    end

    // state register and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= KIND_CMD;
            ce_q     <= 1'b0;
            rdmode_q <= 1'b0;
            wbyte_q  <= '0;
            rbyte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && bus_req && bus_we) begin
                ce_q <= bus_wdata[CE_BIT];
                unique case (req_op)
                    OPC_CMD: begin
                        kind_q   <= KIND_CMD;
                        wbyte_q  <= bus_wdata[BYTE_MSB:BYTE_LSB];
                        rdmode_q <= 1'b0;
                    end
                    OPC_ADDR: begin
                        kind_q   <= KIND_ADDR;
                        wbyte_q  <= bus_wdata[BYTE_MSB:BYTE_LSB];
                        rdmode_q <= 1'b0;
                    end
                    OPC_WRDATA: begin
                        kind_q   <= KIND_DATA;
                        wbyte_q  <= bus_wdata[BYTE_MSB:BYTE_LSB];
                        rdmode_q <= 1'b0;
                    end
                    OPC_RDMODE: rdmode_q <= 1'b1;
                    default: ;
                endcase
            end
            if (state_q == ST_RD_PULSE && tmr_expired) begin
                rbyte_q <= nand_dq_i;
            end
        end
    end

    // pin and bus outputs decoded from registered state
    always_comb begin
        wr_phase   = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE) ||
                     (state_q == ST_WR_HOLD);
        nand_ce_n  = ~ce_q;
        nand_cle   = wr_phase && (kind_q == KIND_CMD);
        nand_ale   = wr_phase && (kind_q == KIND_ADDR);
        nand_we_n  = (state_q != ST_WR_PULSE);
        nand_re_n  = (state_q != ST_RD_PULSE);
        nand_dq_oe = wr_phase;
        nand_dq_o  = wbyte_q;
        bus_ack    = (state_q == ST_DONE);
        bus_rdata  = '0;
        bus_rdata[BYTE_MSB:BYTE_LSB] = rbyte_q;
        bus_rdata[BUSY_BIT]          = busy_sync;
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R1
    AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale))); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R4
    AST_WE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe); // R10
    AST_RE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R10
    AST_ACK_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (nand_we_n && nand_re_n && !nand_dq_oe)); // R11
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R11
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[31:24] == 8'h00 && bus_rdata[14:0] == 15'h0)); // R9
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge #(
    parameter int WE_LO_CYC = 2,
    parameter int WE_HI_CYC = 2,
    parameter int RE_LO_CYC = 2,
    parameter int RE_HI_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rb_n
);
    localparam int MAX_WE  = (WE_LO_CYC > WE_HI_CYC) ? WE_LO_CYC : WE_HI_CYC;
    localparam int MAX_RE  = (RE_LO_CYC > RE_HI_CYC) ? RE_LO_CYC : RE_HI_CYC;
    localparam int MAX_CYC = (MAX_WE > MAX_RE) ? MAX_WE : MAX_RE;
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;

    logic             busy_sync;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    nandbr_sync #(.STAGES(2)) u_busy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (~nand_rb_n),
        .q_sync  (busy_sync)
    );

    nandbr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nandbr_fsm #(
        .WE_LO_CYC (WE_LO_CYC),
        .WE_HI_CYC (WE_HI_CYC),
        .RE_LO_CYC (RE_LO_CYC),
        .RE_HI_CYC (RE_HI_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ack     (bus_ack),
        .busy_sync   (busy_sync),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired),
        .nand_ce_n   (nand_ce_n),
        .nand_cle    (nand_cle),
        .nand_ale    (nand_ale),
        .nand_we_n   (nand_we_n),
        .nand_re_n   (nand_re_n),
        .nand_dq_o   (nand_dq_o),
        .nand_dq_oe  (nand_dq_oe),
        .nand_dq_i   (nand_dq_i)
    );
endmodule

// File: tb/test_nand_reg_bridge.sv
module test_nand_reg_bridge;
    localparam int WLO = 2, WHI = 2, RLO = 2, RHI = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb_n = 1'b1;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    nand_reg_bridge #(.WE_LO_CYC(WLO), .WE_HI_CYC(WHI), .RE_LO_CYC(RLO), .RE_HI_CYC(RHI))
    i_nand_reg_bridge (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    // flash model: presents a computed byte sequence, advancing on read-strobe rise
    function automatic logic [7:0] flash_byte(input int k);
        return 8'((k * 29 + 75) & 255);
    endfunction
    int fl_ptr = 0;
    assign nand_dq_i = flash_byte(fl_ptr);
    always @(posedge nand_re_n) if (rst_n) fl_ptr++;

    // pin event log
    int we_rises = 0, re_rises = 0;
    logic ev_cle, ev_ale, ev_ce_n;
    logic [7:0] ev_byte;
    always @(posedge nand_we_n) if (rst_n) begin
        we_rises++;
        ev_cle = nand_cle; ev_ale = nand_ale; ev_ce_n = nand_ce_n; ev_byte = nand_dq_o;
    end
    always @(posedge nand_re_n) if (rst_n) re_rises++;

    // timing monitors (sampled mid-cycle)
    int we_lo_n = 0, re_lo_n = 0, oe_n = 0;
    int err_we_w = 0, err_re_w = 0, err_oe_w = 0, err_stable = 0, err_oe_re = 0;
    logic [7:0] dq_at_fall;
    always @(negedge clk) if (rst_n) begin
        if (!nand_we_n) begin
            if (we_lo_n == 0) dq_at_fall = nand_dq_o;
            else if (nand_dq_o != dq_at_fall) err_stable++;
            we_lo_n++;
        end else if (we_lo_n != 0) begin
            if (we_lo_n != WLO) err_we_w++;
            we_lo_n = 0;
        end
        if (!nand_re_n) re_lo_n++;
        else if (re_lo_n != 0) begin
            if (re_lo_n != RLO) err_re_w++;
            re_lo_n = 0;
        end
        if (nand_dq_oe) oe_n++;
        else if (oe_n != 0) begin
            if (oe_n != 2 * WHI + WLO) err_oe_w++;
            oe_n = 0;
        end
        if (nand_dq_oe && !nand_re_n) err_oe_re++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit we, input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bus_ack && cyc < 100);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    // bench-side model
    bit         m_rdmode = 0;
    logic [7:0] m_last = 8'h00;
    int         m_ptr = 0;
    logic       m_busy = 0;

    function automatic logic [31:0] mkw(input bit ce, input logic [2:0] op, input logic [7:0] b);
        return {ce, op, 4'h0, b, 16'h0};
    endfunction

    task automatic do_write(input bit ce, input logic [2:0] op, input logic [7:0] b);
        logic [31:0] rd;
        int cyc, w0, r0;
        w0 = we_rises; r0 = re_rises;
        xfer(1'b1, mkw(ce, op, b), rd, cyc);
        chk(cyc < 100, "R11 ack", 32'(cyc), 32'd99);
        chk(nand_ce_n == !ce, "R3 ce", 32'(nand_ce_n), 32'(!ce));
        chk(re_rises == r0, "R4 no read strobe on write", 32'(re_rises - r0), 0);
        if (op == 3'd0 || op == 3'd1 || op == 3'd3) begin
            chk(we_rises == w0 + 1, "R1 one write pulse", 32'(we_rises - w0), 1);
            chk(ev_byte == b, "R1 byte", 32'(ev_byte), 32'(b));
            chk(ev_cle == (op == 3'd0) && ev_ale == (op == 3'd1), "R1 latch kind",
                {30'd0, ev_cle, ev_ale}, {30'd0, op == 3'd0, op == 3'd1});
            chk(ev_ce_n == !ce, "R3 ce during cycle", 32'(ev_ce_n), 32'(!ce));
            m_rdmode = 0;
        end else begin
            chk(we_rises == w0, "R6 no write pulse", 32'(we_rises - w0), 0);
            if (op == 3'd2) m_rdmode = 1;
        end
    endtask

    task automatic do_read(input string tag);
        logic [31:0] rd;
        int cyc, r0, w0;
        logic [7:0] expb;
        r0 = re_rises; w0 = we_rises;
        xfer(1'b0, 32'h0, rd, cyc);
        if (m_rdmode) begin
            expb = flash_byte(m_ptr);
            m_ptr++;
            m_last = expb;
            chk(re_rises == r0 + 1, {"R4 one read pulse ", tag}, 32'(re_rises - r0), 1);
            chk(rd[23:16] == expb, {"R5 sequential byte ", tag}, 32'(rd[23:16]), 32'(expb));
        end else begin
            chk(re_rises == r0, {"R7 no read pulse ", tag}, 32'(re_rises - r0), 0);
            chk(rd[23:16] == m_last, {"R7 last byte ", tag}, 32'(rd[23:16]), 32'(m_last));
        end
        chk(we_rises == w0, {"R11 no write pulse on read ", tag}, 32'(we_rises - w0), 0);
        chk(rd[15] == m_busy, {"R8 busy ", tag}, 32'(rd[15]), 32'(m_busy));
        chk(rd[31:24] == 0 && rd[14:0] == 0, {"R9 unused ", tag}, rd, {8'h0, rd[23:16], rd[15], 15'h0});
    endtask

    task automatic set_busy(input bit b);
        nand_rb_n = !b;
        m_busy = b;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R12 reset state
        chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, bus_ack} == 7'b1110000,
            "R12 reset pins", {25'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, bus_ack},
            32'b1110000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read("R12 after reset");

        // directed: command, address, data, read-mode
        do_write(1, 3'd0, 8'h90);
        do_write(1, 3'd1, 8'h00);
        do_write(1, 3'd3, 8'hA5);
        do_read("outside read mode");
        do_write(1, 3'd2, 8'h00);
        do_read("rd1");
        do_read("rd2");
        do_read("rd3");
        // R6 undefined op keeps read mode, changes CE only
        do_write(0, 3'd5, 8'hFF);
        do_read("after undefined op");
        do_write(1, 3'd7, 8'h11);
        // leaving read mode by data write
        do_write(1, 3'd3, 8'h3C);
        do_read("R7 after leaving");
        // R8 busy levels
        set_busy(1); do_read("busy");
        set_busy(0); do_read("ready");

        // coincidence: busy falls while the read strobe is low
        do_write(1, 3'd2, 8'h00);
        fork
            do_read("busy during fetch R8 R5");
            begin
                @(negedge nand_re_n);
                nand_rb_n = 1'b0;
                m_busy = 1;
            end
        join
        set_busy(0);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int sel;
            sel = int'($urandom % 10);
            if ($urandom % 5 == 0) set_busy(bit'($urandom % 2));
            if (sel >= 8) do_read("random");
            else do_write(bit'($urandom % 2), 3'(sel), 8'($urandom));
        end

        repeat (4) @(negedge clk);
        chk(err_we_w == 0, "R2 write low width", 32'(err_we_w), 0);
        chk(err_stable == 0, "R2 data stable", 32'(err_stable), 0);
        chk(err_oe_w == 0, "R10 drive window", 32'(err_oe_w), 0);
        chk(err_oe_re == 0, "R10 no drive during read", 32'(err_oe_re), 0);
        chk(err_re_w == 0, "R4 read low width", 32'(err_re_w), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule